// File: doc/BRIEF.md
# Weighted-Slot Dispatch Group Tracker

This block follows an in-order issue stage as it packs instructions into fixed-size dispatch groups of six slot positions. Each instruction comes in on a valid/ready handshake. It carries a slot-cost class, a record-form flag, a branch flag, a must-lead flag and a load flag, plus an optional dependency: the tag of an earlier instruction and whether that producer wrote the counter register or was a store. The decoder upstream computes all of these flags. The block counts the slots used and the branches seen. It keeps the tags of the instructions in the open group and decides when a new group starts.

If the presented instruction depends on a member of the open group in a hazardous way, the block reports how many filler no-ops the issue stage must emit first. The hazardous cases are a load after a store and a branch after a counter-register write. While that count is nonzero, the block holds the instruction back. The issue stage reports each emitted filler through a single-cycle no-op pulse. A mode input selects how no-ops behave. In counted mode the fillers pad the group up to its fifth slot. In the other mode a single no-op ends the group.

Top module: `dgt_tracker`

## Requirements
- R1: After a synchronous reset, slot_count is 0, branch_seen is 0 and the member list is empty, so no dependency raises hazard.
- R2: The in_cost field encodes the slot cost as 0 = one slot, 1 = two slots, and 2 or 3 = four slots. A class-0 instruction with in_rec set costs two slots.
- R3: An instruction costing more than one slot, or one with in_lead set, must lead a group. If slot_count is nonzero when it is accepted, the group is emptied first, and then slot_count becomes its own cost with only its tag as a member.
- R4: An instruction accepted while slot_count is 5 or more empties the group. Afterwards slot_count is 0, branch_seen is 0, and the instruction is neither counted nor kept as a member.
- R5: The first accepted branch in a group sets branch_seen. A branch accepted while branch_seen is 1 empties the group in the same way as R4.
- R6: hazard is 1 only when in_valid and dep_valid are set, dep_tag matches a member of the open group, and either dep_is_ctr=0 with in_load=1 or dep_is_ctr=1 with in_branch=1.
- R7: fill_count is 0 without a hazard or when slot_count is 6. With a hazard it is 5 minus slot_count when term_nop_mode=0, and 1 when term_nop_mode=1.
- R8: in_ready is 1 exactly when fill_count is 0 and nop_pulse is 0. An instruction presented while in_ready is 0 leaves the state unchanged.
- R9: A nop_pulse ends the group (slot_count 0, branch_seen 0, list emptied) when term_nop_mode=1 or slot_count is 6. Otherwise it adds one empty slot and leaves the members unchanged.
- R10: Once a group has been emptied, a tag from that group no longer raises hazard.
- R11: Any other accepted instruction adds its cost to slot_count and joins the member list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_nop_mode | input | 1 | 1: a single no-op ends the group |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Instruction may be accepted this cycle |
| in_tag | input | TAG_W | Tag of the presented instruction |
| in_cost | input | 2 | Slot-cost class |
| in_rec | input | 1 | Record form (also sets a condition field) |
| in_branch | input | 1 | Instruction is a branch |
| in_lead | input | 1 | Must lead a group regardless of cost |
| in_load | input | 1 | Instruction is a load |
| dep_valid | input | 1 | A dependency on an earlier instruction exists |
| dep_tag | input | TAG_W | Tag of the producer instruction |
| dep_is_ctr | input | 1 | 1: producer wrote the counter register; 0: producer is a store |
| nop_pulse | input | 1 | The issue stage emitted one no-op this cycle |
| hazard | output | 1 | Dependency on a member of the open group |
| fill_count | output | 3 | No-ops still needed before the instruction may go |
| slot_count | output | 3 | Slots used in the open group |
| branch_seen | output | 1 | The open group already holds a branch |

## Verification
The hazard, fill_count and in_ready outputs are combinational in the current state and the presented inputs, so they are due in the same cycle the stimulus is applied. slot_count and branch_seen change on the rising edge that accepts an instruction or takes a no-op pulse, so they are due exactly one edge later. The bench drives inputs on the falling edge and samples the combinational results 1 ns later. After the next rising edge it updates its reference model, and it compares the registered outputs at the following sample point. Directed sequences walk the group boundaries at slot counts 5 and 6, and a long random walk compares every cycle in both no-op modes.

// File: rtl/dgt_pkg.sv
package dgt_pkg;

    typedef enum logic [1:0] {
        COST_ONE  = 2'd0,
        COST_TWO  = 2'd1,
        COST_FOUR = 2'd2,
        COST_RSVD = 2'd3
    } cost_cls_e;

    typedef struct packed {
        cost_cls_e cls;
        logic      rec;
        logic      branch;
        logic      lead;
        logic      load;
    } instr_attr_t;

    // slot cost of one instruction; a record-form single becomes a double
    function automatic logic [2:0] slot_cost(cost_cls_e cls, logic rec);
        logic [2:0] c;
        case (cls)
            COST_ONE: c = rec ? 3'd2 : 3'd1;
            COST_TWO: c = 3'd2;
            default:  c = 3'd4;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dgt_cost.sv
module dgt_cost
    import dgt_pkg::*;
#(
    parameter int CW = 3
) (
    input  instr_attr_t   attr,
    output logic [CW-1:0] cost,
    output logic          must_lead
);
    logic [2:0] raw;

    always_comb begin
        raw       = slot_cost(attr.cls, attr.rec);
        cost      = CW'(raw);
        must_lead = (raw > 3'd1) || attr.lead;
    end
endmodule

// File: rtl/dgt_members.sv
module dgt_members #(
    parameter int TAG_W = 4,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] hit_vec;
    logic [PW-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= push ? PW'(1) : '0;
        end else if (push) begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic wr;
        assign wr = push && (clear ? (i == 0) : (cnt_q == PW'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
            end else if (wr) begin
                vld_q[i] <= 1'b1;
            end else if (clear) begin
                vld_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr) tag_q[i] <= push_tag;
        end

        assign hit_vec[i] = vld_q[i] && (tag_q[i] == probe_tag);
    end

    assign hit = |hit_vec;

    // R10: the list never grows past its depth within one group
    p_list_room_r10: assert property (@(posedge clk) disable iff (rst)
        (push && !clear) |-> (cnt_q < DEPTH_V));
endmodule

// File: rtl/dgt_fill.sv
module dgt_fill #(
    parameter int CW          = 3,
    parameter int GROUP_SLOTS = 6
) (
    input  logic          hazard,
    input  logic          term_mode,
    input  logic [CW-1:0] slots,
    output logic [CW-1:0] fill
);
    localparam logic [CW-1:0] FULL_V  = CW'(GROUP_SLOTS);
    localparam logic [CW-1:0] LIMIT_V = CW'(GROUP_SLOTS - 1);

    always_comb begin
        if (!hazard || (slots >= FULL_V)) begin
            fill = '0;
        end else if (term_mode) begin
            fill = CW'(1);
        end else if (slots >= LIMIT_V) begin
            fill = '0;
        end else begin
            fill = LIMIT_V - slots;
        end
    end
endmodule

// File: rtl/dgt_tracker.sv
module dgt_tracker
    import dgt_pkg::*;
#(
    parameter int TAG_W       = 4,
    parameter int GROUP_SLOTS = 6,
    parameter int LIST_DEPTH  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             term_nop_mode,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [1:0]       in_cost,
    input  logic             in_rec,
    input  logic             in_branch,
    input  logic             in_lead,
    input  logic             in_load,
    input  logic             dep_valid,
    input  logic [TAG_W-1:0] dep_tag,
    input  logic             dep_is_ctr,
    input  logic             nop_pulse,
    output logic             hazard,
    output logic [2:0]       fill_count,
    output logic [2:0]       slot_count,
    output logic             branch_seen
);
    localparam int CW = $clog2(GROUP_SLOTS + 1);
    localparam logic [CW-1:0] FULL_V = CW'(GROUP_SLOTS);
    localparam logic [CW-1:0] LAST_V = CW'(GROUP_SLOTS - 1);

    instr_attr_t   attr;
    logic [CW-1:0] cost;
    logic          must_lead;
    logic          dep_hit;
    logic [CW-1:0] fill;
    logic          accept;

    logic [CW-1:0] slots_q, slots_d, base;
    logic          brc_q, brc_d, brc_base;
    logic          lst_clear, lst_push;

    assign attr = '{cls: cost_cls_e'(in_cost), rec: in_rec, branch: in_branch,
                    lead: in_lead, load: in_load};

    dgt_cost #(.CW(CW)) u_cost (
        .attr      (attr),
        .cost      (cost),
        .must_lead (must_lead)
    );

    dgt_members #(.TAG_W(TAG_W), .DEPTH(LIST_DEPTH)) u_list (
        .clk       (clk),
        .rst       (rst),
        .clear     (lst_clear),
        .push      (lst_push),
        .push_tag  (in_tag),
        .probe_tag (dep_tag),
        .hit       (dep_hit)
    );

    assign hazard = in_valid && dep_valid && dep_hit &&
                    (dep_is_ctr ? in_branch : in_load);

    dgt_fill #(.CW(CW), .GROUP_SLOTS(GROUP_SLOTS)) u_fill (
        .hazard    (hazard),
        .term_mode (term_nop_mode),
        .slots     (slots_q),
        .fill      (fill)
    );

    assign in_ready = (fill == '0) && !nop_pulse;
    assign accept   = in_valid && in_ready;

    always_comb begin
        slots_d   = slots_q;
        brc_d     = brc_q;
        lst_clear = 1'b0;
        lst_push  = 1'b0;
        base      = slots_q;
        brc_base  = brc_q;
        if (accept) begin
            if ((slots_q >= LAST_V) || (in_branch && brc_q)) begin
                slots_d   = '0;
                brc_d     = 1'b0;
                lst_clear = 1'b1;
            end else begin
                if (must_lead && (slots_q != '0)) begin
                    base      = '0;
                    brc_base  = 1'b0;
                    lst_clear = 1'b1;
                end
                slots_d  = base + cost;
                brc_d    = brc_base | in_branch;
                lst_push = 1'b1;
            end
        end else if (nop_pulse) begin
            if (term_nop_mode || (slots_q >= FULL_V)) begin
                slots_d   = '0;
                brc_d     = 1'b0;
                lst_clear = 1'b1;
            end else begin
                slots_d = slots_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            brc_q   <= 1'b0;
        end else begin
            slots_q <= slots_d;
            brc_q   <= brc_d;
        end
    end

    assign slot_count  = 3'(slots_q);
    assign fill_count  = 3'(fill);
    assign branch_seen = brc_q;

    // R9: slot usage never exceeds the group size
    p_slots_cap_r9: assert property (@(posedge clk) disable iff (rst)
        slots_q <= FULL_V);

    // R9: in terminating mode a no-op always ends the group
    p_term_nop_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (nop_pulse && term_nop_mode) |=> (slots_q == '0 && !brc_q));

    // R9: in counted mode a no-op below a full group adds one slot
    p_nop_adds_r9: assert property (@(posedge clk) disable iff (rst)
        (nop_pulse && !term_nop_mode && slots_q < FULL_V)
        |=> (slots_q == $past(slots_q) + CW'(1)));

    // R5: a second branch empties the group
    p_second_branch_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && in_branch && brc_q) |=> (slots_q == '0 && !brc_q));

    // R3: a four-slot instruction always ends up alone at the group head
    p_wide_leads_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && in_cost[1] && slots_q < LAST_V && !(in_branch && brc_q))
        |=> (slots_q == CW'(4)));

    // R7: filler count never exceeds the fillable slots, one in terminating mode
    p_fill_cap_r7: assert property (@(posedge clk) disable iff (rst)
        (fill <= LAST_V) && (!term_nop_mode || fill <= CW'(1)));
endmodule

// File: tb/sim_dgt_tracker.sv
module sim_dgt_tracker;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       term_nop_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_tag = '0;
    logic [1:0] in_cost = '0;
    logic       in_rec = 1'b0, in_branch = 1'b0, in_lead = 1'b0, in_load = 1'b0;
    logic       dep_valid = 1'b0;
    logic [3:0] dep_tag = '0;
    logic       dep_is_ctr = 1'b0;
    logic       nop_pulse = 1'b0;
    logic       hazard;
    logic [2:0] fill_count, slot_count;
    logic       branch_seen;

    int checks = 0;
    int fails  = 0;
    int m_slots = 0;
    int m_br = 0;
    int m_q[$];

    always #(CLK_NS / 2) clk = ~clk;

    dgt_tracker u0 (
        .clk(clk), .rst(rst), .term_nop_mode(term_nop_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
        .in_cost(in_cost), .in_rec(in_rec), .in_branch(in_branch),
        .in_lead(in_lead), .in_load(in_load), .dep_valid(dep_valid),
        .dep_tag(dep_tag), .dep_is_ctr(dep_is_ctr), .nop_pulse(nop_pulse),
        .hazard(hazard), .fill_count(fill_count), .slot_count(slot_count),
        .branch_seen(branch_seen)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_cost(int cls, bit rec);
        if (cls == 0) return rec ? 2 : 1;
        if (cls == 1) return 2;
        return 4;
    endfunction

    task automatic idle();
        in_valid = 0; in_rec = 0; in_branch = 0; in_lead = 0; in_load = 0;
        dep_valid = 0; dep_is_ctr = 0; nop_pulse = 0; in_cost = 0;
    endtask

    task automatic put(int tag, int cls, bit rec, bit br, bit lead, bit ld,
                       bit dv, int dtag, bit dctr);
        in_valid = 1; in_tag = 4'(tag); in_cost = 2'(cls); in_rec = rec;
        in_branch = br; in_lead = lead; in_load = ld; dep_valid = dv;
        dep_tag = 4'(dtag); dep_is_ctr = dctr; nop_pulse = 0;
    endtask

    task automatic nop();
        idle();
        nop_pulse = 1;
    endtask

    // compare one cycle against the reference model, then advance it
    task automatic tick(string req);
        bit hit, hz, rdy, acc, lead;
        int fl, c;
        #1;
        hit = 0;
        foreach (m_q[k]) if (m_q[k] == int'(dep_tag)) hit = 1;
        hz  = in_valid && dep_valid && hit && (dep_is_ctr ? in_branch : in_load);
        fl  = (hz && m_slots < 6) ? (term_nop_mode ? 1 : 5 - m_slots) : 0;
        rdy = (fl == 0) && !nop_pulse;
        check(req, "hazard", int'(hazard), int'(hz));
        check(req, "fill_count", int'(fill_count), fl);
        check(req, "in_ready", int'(in_ready), int'(rdy));
        check(req, "slot_count", int'(slot_count), m_slots);
        check(req, "branch_seen", int'(branch_seen), m_br);
        acc  = in_valid && rdy;
        c    = m_cost(int'(in_cost), in_rec);
        lead = (c > 1) || in_lead;
        @(posedge clk);
        if (acc) begin
            if (m_slots >= 5 || (in_branch && m_br == 1)) begin
                m_slots = 0; m_br = 0; m_q.delete();
            end else begin
                if (lead && m_slots != 0) begin
                    m_slots = 0; m_br = 0; m_q.delete();
                end
                m_slots += c;
                if (in_branch) m_br = 1;
                m_q.push_back(int'(in_tag));
            end
        end else if (nop_pulse) begin
            if (term_nop_mode || m_slots >= 6) begin
                m_slots = 0; m_br = 0; m_q.delete();
            end else begin
                m_slots++;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state, unknown tag gives no hazard
        put(1, 0, 0, 0, 0, 1, 1, 0, 0); tick("R1");
        // that load was accepted; check idle state afterward
        idle(); tick("R11");

        // R11: singles accumulate
        put(2, 0, 0, 0, 0, 0, 0, 0, 0); tick("R11");
        idle(); tick("R11");
        // R2: record-form single costs two and must lead -> group restarts at 2
        put(3, 0, 1, 0, 0, 0, 0, 0, 0); tick("R2");
        idle(); tick("R2");
        // R3: four-slot class leads -> 4
        put(4, 2, 0, 0, 0, 0, 0, 0, 0); tick("R3");
        put(5, 0, 0, 0, 0, 0, 0, 0, 0); tick("R11");
        // R4: at 5 slots the next instruction empties the group uncounted
        put(6, 0, 0, 0, 0, 0, 0, 0, 0); tick("R4");
        put(7, 0, 0, 0, 0, 1, 1, 6, 0); tick("R4");
        // R3: lead flag on a single
        put(8, 0, 0, 0, 1, 0, 0, 0, 0); tick("R3");
        idle(); tick("R3");
        // R2: reserved class counts four
        put(9, 3, 0, 0, 0, 0, 0, 0, 0); tick("R2");
        idle(); tick("R2");

        // R5: two branches
        rst = 1; @(negedge clk); rst = 0; m_slots = 0; m_br = 0; m_q.delete();
        put(1, 0, 0, 1, 0, 0, 0, 0, 0); tick("R5");
        put(2, 0, 0, 1, 0, 0, 0, 0, 0); tick("R5");
        idle(); tick("R5");

        // R6/R7/R8: load after store in counted mode
        put(2, 0, 0, 0, 0, 0, 0, 0, 0); tick("R11");
        put(3, 0, 0, 0, 0, 0, 0, 0, 0); tick("R11");
        put(10, 0, 0, 0, 0, 1, 1, 2, 0); tick("R6");
        put(10, 0, 0, 0, 0, 1, 1, 9, 0); idle(); tick("R6");
        put(10, 0, 0, 0, 0, 0, 1, 2, 0); idle(); tick("R6");
        put(10, 0, 0, 1, 0, 0, 1, 3, 1); tick("R6");
        put(10, 0, 0, 0, 0, 1, 1, 3, 1); tick("R6");
        // R8: nop pulse blocks acceptance
        put(11, 0, 0, 0, 0, 0, 0, 0, 0); nop_pulse = 1; tick("R8");
        nop(); tick("R9");
        nop(); tick("R9");
        put(12, 0, 0, 0, 0, 1, 1, 2, 0); tick("R7");
        idle(); tick("R4");

        // terminating-nop mode
        term_nop_mode = 1;
        put(4, 0, 0, 0, 0, 0, 0, 0, 0); tick("R11");
        put(5, 0, 0, 0, 0, 1, 1, 4, 0); tick("R7");
        nop(); tick("R9");
        put(5, 0, 0, 0, 0, 1, 1, 4, 0); tick("R10");
        idle(); tick("R10");

        // counted mode: nops up to 6, hazard at 6 gives no filler
        term_nop_mode = 0;
        put(6, 2, 0, 0, 0, 0, 0, 0, 0); tick("R3");
        nop(); tick("R9");
        nop(); tick("R9");
        put(7, 0, 0, 0, 0, 1, 1, 6, 0); tick("R7");
        put(8, 1, 0, 0, 0, 0, 0, 0, 0); tick("R3");
        nop(); tick("R9");
        nop(); tick("R9");
        nop(); tick("R9");
        nop(); tick("R9");
        nop(); tick("R9");
        put(9, 0, 0, 0, 0, 1, 1, 8, 0); tick("R10");
        idle(); tick("R10");

        // random walk in both modes
        for (int i = 0; i < 600; i++) begin
            if (i % 60 == 0) term_nop_mode = ~term_nop_mode;
            if ($urandom_range(0, 4) == 0) begin
                nop();
                if ($urandom_range(0, 1) == 1) begin
                    in_valid = 1; in_load = 1; dep_valid = 1;
                    dep_tag = 4'($urandom_range(0, 3));
                end
            end else if ($urandom_range(0, 5) == 0) begin
                idle();
            end else begin
                put($urandom_range(0, 3), $urandom_range(0, 3) == 0 ? 1 :
                    ($urandom_range(0, 7) == 0 ? 2 : 0),
                    $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0,
                    $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, $urandom_range(0, 3),
                    $urandom_range(0, 1) == 1);
            end
            tick("R6");
        end

        idle(); tick("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule